// File: doc/BRIEF.md
# Reference Clock Output Selector with Loss Fallback

This block picks one reference clock for a chip output pin. The source is one of 29 per-channel recovered line clocks or one external T1/E1 clock input. For a channel source, a configuration bit chooses the tap either before or after the receive jitter attenuator. The selected clock can leave the block unchanged, or the block can substitute an externally generated synthesizer clock or a clock locked to the master clock. A free-run mode always delivers the master-locked clock.

The block also handles failures. When the selected channel reports loss of signal, a hold bit decides the output: it is either forced high or replaced by the master-locked clock. The external input is watched by a tick counter in the master-clock domain. When that input stops toggling for longer than a parameterised window, the output goes high, unless free-run is active.

All clocks are treated as oversampled levels in the master-clock domain. Every change of source goes through a two-step glitch-free handover: the old source is released while it is low, and the new one is taken on while it is low. The output therefore never carries a pulse shorter than a phase of the source that produced it.

Top module: `refClkSel`

## Requirements
- R1: With `cfgEnable` low, `refClkOe` is low one cycle later and the selection falls back to a constant low output. With `cfgEnable` high, `refClkOe` is high one cycle later. Both signals are low in reset.
- R2: `cfgSrcSel` values 0 to 28 select channel clock N. Values 29, 30 and 31 (5'b11101 to 5'b11111) select `extClk`. In steady state the output follows the selected source with a latency of two clock cycles.
- R3: For a channel source, `cfgJaBypass`=1 takes `chRecClk[N]` (before the attenuator) and `cfgJaBypass`=0 takes `chJaClk[N]`.
- R4: With `cfgSynthBypass`=1 and no fault, the output is the selected source itself.
- R5: With `cfgSynthBypass`=0, `cfgFreeRun`=0 and no fault, the output is `synthClk`.
- R6: With `cfgSynthBypass`=0 and `cfgFreeRun`=1, the output is `mlockClk` whatever the source or fault state. The exception is a reserved frequency code (see R7).
- R7: In free-run, the reserved frequency codes 3'b000 and 3'b011 drive the output constantly high.
- R8: When the selected channel has `chLos` set and free-run is off: `cfgHoldHigh`=1 drives the output high, and `cfgHoldHigh`=0 gives `mlockClk`. LOS flags of unselected channels have no effect.
- R9: The external input is declared lost once no rising edge has been seen for `LOSS_TICKS_T1` master ticks (`cfgT1E1`=0) or `LOSS_TICKS_E1` ticks (`cfgT1E1`=1). A rising edge restarts the window.
- R10: When the external source is selected and lost, the output is high unless free-run is active.
- R11: The loss flag clears only on the second rising edge after the loss. A single edge leaves the output in its fallback state.
- R12: A change of source first drops the output while the old source is low, and then takes on the new source while it is low. The output holds low between the two steps, so no output high pulse is shorter than the source high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all sampling and state |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Output enable field |
| cfgSrcSel | input | 5 | Source code: 0-28 channel, 29-31 external |
| cfgT1E1 | input | 1 | External clock rate: 0 T1, 1 E1 (loss window) |
| cfgJaBypass | input | 1 | 1 takes the recovered clock before the jitter attenuator |
| cfgSynthBypass | input | 1 | 1 bypasses the synthesizer |
| cfgFreeRun | input | 1 | Free-run request (with synthesizer enabled) |
| cfgHoldHigh | input | 1 | Channel LOS reaction: 1 high, 0 master-locked |
| cfgFreq | input | 3 | Synthesizer frequency code; 000 and 011 reserved in free-run |
| chRecClk | input | 29 | Recovered clock per channel |
| chJaClk | input | 29 | Jitter-attenuated clock per channel |
| chLos | input | 29 | Line LOS flag per channel |
| extClk | input | 1 | External T1/E1 reference input |
| synthClk | input | 1 | Synthesizer output clock |
| mlockClk | input | 1 | Clock locked to the master clock |
| refClkOut | output | 1 | Selected reference clock |
| refClkOe | output | 1 | Output driver enable (low means high-impedance) |

## Verification
A wrong source decode or a wrong fault priority shows at `refClkOut` within about one source period: the output tracks the wrong clock or sits at a constant level where a clock is expected. A loss counter that runs too far or too short shows as an output going high a few hundred cycles too early or too late. The bench places its checks on either side of the T1 and E1 windows to catch this. A broken handover state shows as an output high pulse shorter than any source phase, or as a pulse taken from the source being released.

// File: rtl/refClkPkg.sv
package refClkPkg;
  localparam int SEL_W = 5;

  typedef enum logic [2:0] {
    SRC_LOW,
    SRC_HIGH,
    SRC_DIRECT,
    SRC_SYNTH,
    SRC_MLOCK
  } srcKind_e;

  // what the datapath should gate onto the output
  typedef struct packed {
    srcKind_e         kind;
    logic [SEL_W-1:0] idx;     // only meaningful for SRC_DIRECT
    logic             useRec;  // only meaningful for SRC_DIRECT
  } srcSel_t;

  typedef struct packed {
    srcSel_t sel;
    logic    outEn;
  } pathReq_t;
endpackage

// File: rtl/extLossDet.sv
module extLossDet #(
  parameter int LOSS_TICKS_T1 = 648,
  parameter int LOSS_TICKS_E1 = 488
) (
  input  logic clk,
  input  logic rstN,
  input  logic extClk,
  input  logic isE1,
  output logic edgePulse,
  output logic lost
);
  localparam int MAXT = (LOSS_TICKS_T1 > LOSS_TICKS_E1) ? LOSS_TICKS_T1 : LOSS_TICKS_E1;
  localparam int CW   = $clog2(MAXT + 1);

  logic [2:0]    syncQ;
  logic [CW-1:0] tickCnt;
  logic [CW-1:0] limit;
  logic          seenOne;
  logic          expired;

  assign edgePulse = syncQ[1] & ~syncQ[2];
  assign limit     = isE1 ? CW'(LOSS_TICKS_E1) : CW'(LOSS_TICKS_T1);
  assign expired   = (tickCnt >= limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      tickCnt <= '0;
      lost    <= 1'b0;
      seenOne <= 1'b0;
    end else begin
      syncQ <= {syncQ[1:0], extClk};
      if (edgePulse)     tickCnt <= '0;
      else if (!expired) tickCnt <= tickCnt + 1'b1;

      if (!lost) begin
        seenOne <= 1'b0;
        if (!edgePulse && expired) lost <= 1'b1;
      end else if (edgePulse) begin
        // recovery needs a second edge inside one window
        if (seenOne) begin
          lost    <= 1'b0;
          seenOne <= 1'b0;
        end else begin
          seenOne <= 1'b1;
        end
      end else if (expired) begin
        seenOne <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/refClkCtrl.sv
module refClkCtrl import refClkPkg::*; #(
  parameter int NUM_CH        = 29,
  parameter int LOSS_TICKS_T1 = 648,
  parameter int LOSS_TICKS_E1 = 488
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [SEL_W-1:0]  cfgSrcSel,
  input  logic              cfgT1E1,
  input  logic              cfgJaBypass,
  input  logic              cfgSynthBypass,
  input  logic              cfgFreeRun,
  input  logic              cfgHoldHigh,
  input  logic [2:0]        cfgFreq,
  input  logic [NUM_CH-1:0] chLos,
  input  logic              extClk,
  output pathReq_t          req,
  output logic              extEdge,
  output logic              extLost
);
  logic isExt;
  logic selLos;
  logic freeMode;
  logic badCode;

  extLossDet #(
    .LOSS_TICKS_T1(LOSS_TICKS_T1),
    .LOSS_TICKS_E1(LOSS_TICKS_E1)
  ) u_loss (
    .clk      (clk),
    .rstN     (rstN),
    .extClk   (extClk),
    .isE1     (cfgT1E1),
    .edgePulse(extEdge),
    .lost     (extLost)
  );

  assign isExt    = (32'(cfgSrcSel) >= NUM_CH);
  assign selLos   = !isExt && chLos[cfgSrcSel];
  assign freeMode = !cfgSynthBypass && cfgFreeRun;
  assign badCode  = (cfgFreq == 3'b000) || (cfgFreq == 3'b011);

  // priority: disabled, free-run, source fault, normal path
  always_comb begin
    req.outEn      = cfgEnable;
    req.sel.kind   = SRC_LOW;
    req.sel.idx    = '0;
    req.sel.useRec = 1'b0;
    if (!cfgEnable) begin
      req.sel.kind = SRC_LOW;
    end else if (freeMode) begin
      req.sel.kind = badCode ? SRC_HIGH : SRC_MLOCK;
    end else if (isExt && extLost) begin
      req.sel.kind = SRC_HIGH;
    end else if (selLos) begin
      req.sel.kind = cfgHoldHigh ? SRC_HIGH : SRC_MLOCK;
    end else if (cfgSynthBypass) begin
      req.sel.kind   = SRC_DIRECT;
      req.sel.idx    = cfgSrcSel;
      req.sel.useRec = cfgJaBypass;
    end else begin
      req.sel.kind = SRC_SYNTH;
    end
  end
endmodule

// File: rtl/refClkPath.sv
module refClkPath import refClkPkg::*; #(
  parameter int NUM_CH = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathReq_t          req,
  input  logic [NUM_CH-1:0] chRecClk,
  input  logic [NUM_CH-1:0] chJaClk,
  input  logic              extClk,
  input  logic              synthClk,
  input  logic              mlockClk,
  output logic              clkOut,
  output logic              clkOe,
  output srcSel_t           heldSel
);
  typedef enum logic {ST_RUN, ST_GAP} swState_e;

  logic [NUM_CH-1:0] recSmp;
  logic [NUM_CH-1:0] jaSmp;
  logic              extSmp;
  logic              synSmp;
  logic              mlkSmp;
  swState_e          state;
  logic              heldVal;
  logic              reqVal;
  logic              heldFree;
  logic              reqReady;

  function automatic logic levelOf(input srcSel_t s,
                                   input logic [NUM_CH-1:0] rec,
                                   input logic [NUM_CH-1:0] ja,
                                   input logic ext, input logic syn,
                                   input logic mlk);
    logic v;
    case (s.kind)
      SRC_HIGH:   v = 1'b1;
      SRC_SYNTH:  v = syn;
      SRC_MLOCK:  v = mlk;
      SRC_DIRECT: begin
        if (32'(s.idx) >= NUM_CH) v = ext;
        else if (s.useRec)        v = rec[s.idx];
        else                      v = ja[s.idx];
      end
      default:    v = 1'b0;
    endcase
    return v;
  endfunction

  assign heldVal  = levelOf(heldSel, recSmp, jaSmp, extSmp, synSmp, mlkSmp);
  assign reqVal   = levelOf(req.sel, recSmp, jaSmp, extSmp, synSmp, mlkSmp);
  // a constant-high source has no low phase; it is released/taken at once
  assign heldFree = (heldSel.kind == SRC_HIGH) || !heldVal;
  assign reqReady = (req.sel.kind == SRC_HIGH) || !reqVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recSmp         <= '0;
      jaSmp          <= '0;
      extSmp         <= 1'b0;
      synSmp         <= 1'b0;
      mlkSmp         <= 1'b0;
      state          <= ST_RUN;
      heldSel.kind   <= SRC_LOW;
      heldSel.idx    <= '0;
      heldSel.useRec <= 1'b0;
      clkOut         <= 1'b0;
      clkOe          <= 1'b0;
    end else begin
      recSmp <= chRecClk;
      jaSmp  <= chJaClk;
      extSmp <= extClk;
      synSmp <= synthClk;
      mlkSmp <= mlockClk;
      clkOe  <= req.outEn;
      case (state)
        ST_RUN: begin
          if ((req.sel != heldSel) && heldFree) begin
            clkOut <= 1'b0;
            state  <= ST_GAP;
          end else begin
            clkOut <= heldVal;
          end
        end
        default: begin
          clkOut <= 1'b0;
          if (reqReady) begin
            heldSel <= req.sel;
            state   <= ST_RUN;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/refClkSel.sv
module refClkSel import refClkPkg::*; #(
  parameter int NUM_CH        = 29,
  parameter int LOSS_TICKS_T1 = 648,
  parameter int LOSS_TICKS_E1 = 488
) (
  input  logic              mclk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [4:0]        cfgSrcSel,
  input  logic              cfgT1E1,
  input  logic              cfgJaBypass,
  input  logic              cfgSynthBypass,
  input  logic              cfgFreeRun,
  input  logic              cfgHoldHigh,
  input  logic [2:0]        cfgFreq,
  input  logic [NUM_CH-1:0] chRecClk,
  input  logic [NUM_CH-1:0] chJaClk,
  input  logic [NUM_CH-1:0] chLos,
  input  logic              extClk,
  input  logic              synthClk,
  input  logic              mlockClk,
  output logic              refClkOut,
  output logic              refClkOe
);
  pathReq_t pathReq;
  srcSel_t  heldSel;
  logic     extEdge;
  logic     extLost;

  refClkCtrl #(
    .NUM_CH       (NUM_CH),
    .LOSS_TICKS_T1(LOSS_TICKS_T1),
    .LOSS_TICKS_E1(LOSS_TICKS_E1)
  ) u_ctrl (
    .clk           (mclk),
    .rstN          (rstN),
    .cfgEnable     (cfgEnable),
    .cfgSrcSel     (cfgSrcSel),
    .cfgT1E1       (cfgT1E1),
    .cfgJaBypass   (cfgJaBypass),
    .cfgSynthBypass(cfgSynthBypass),
    .cfgFreeRun    (cfgFreeRun),
    .cfgHoldHigh   (cfgHoldHigh),
    .cfgFreq       (cfgFreq),
    .chLos         (chLos),
    .extClk        (extClk),
    .req           (pathReq),
    .extEdge       (extEdge),
    .extLost       (extLost)
  );

  refClkPath #(.NUM_CH(NUM_CH)) u_path (
    .clk     (mclk),
    .rstN    (rstN),
    .req     (pathReq),
    .chRecClk(chRecClk),
    .chJaClk (chJaClk),
    .extClk  (extClk),
    .synthClk(synthClk),
    .mlockClk(mlockClk),
    .clkOut  (refClkOut),
    .clkOe   (refClkOe),
    .heldSel (heldSel)
  );
endmodule

// File: rtl/refClkSelChk.sv
module refClkSelChk import refClkPkg::*; (
  input logic    clk,
  input logic    rstN,
  input logic    cfgEnable,
  input logic    refClkOe,
  input logic    refClkOut,
  input logic    extEdge,
  input logic    extLost,
  input srcSel_t heldSel
);
  a_r1_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !refClkOe);

  a_r1_oe_on: assert property (@(posedge clk) disable iff (!rstN)
    cfgEnable |=> refClkOe);

  a_r12_swap_low: assert property (@(posedge clk) disable iff (!rstN)
    (heldSel != $past(heldSel)) |-> !$past(refClkOut));

  a_r9_edge_keeps_lock: assert property (@(posedge clk) disable iff (!rstN)
    extEdge |=> !$rose(extLost));

  a_r11_clear_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extLost) |-> $past(extEdge));
endmodule

bind refClkSel refClkSelChk u_chk (
  .clk      (mclk),
  .rstN     (rstN),
  .cfgEnable(cfgEnable),
  .refClkOe (refClkOe),
  .refClkOut(refClkOut),
  .extEdge  (extEdge),
  .extLost  (extLost),
  .heldSel  (heldSel)
);

// File: tb/test_refClkSel.sv
`timescale 1ns/1ps
module test_refClkSel;
  logic        mclk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [4:0]  cfgSrcSel = '0;
  logic        cfgT1E1 = 1'b0;
  logic        cfgJaBypass = 1'b1;
  logic        cfgSynthBypass = 1'b1;
  logic        cfgFreeRun = 1'b0;
  logic        cfgHoldHigh = 1'b0;
  logic [2:0]  cfgFreq = 3'b010;
  logic [28:0] chRecClk;
  logic [28:0] chJaClk;
  logic [28:0] chLos = '0;
  logic        extClk;
  logic        synthClk;
  logic        mlockClk;
  logic        refClkOut;
  logic        refClkOe;

  // bench sources: 0 rec, 1 rec of ch7, 2 ja, 3 ext, 4 synth, 5 mlock
  logic [5:0] srcNow = '0;
  logic [5:0] prevSrc = '0;
  int  cyc = 0;
  int  extCnt = 0;
  bit  extRun = 1'b1;
  logic extForce = 1'b0;
  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;
  int  runLen = 0;
  logic lastOut = 1'b0;
  int  shortPulses = 0;

  always #4 mclk = ~mclk;

  always @(negedge mclk) begin
    prevSrc = srcNow;
    cyc++;
    if (extRun) extCnt++;
    srcNow[0] = (cyc % 10) < 5;
    srcNow[1] = (cyc % 8) < 4;
    srcNow[2] = (cyc % 6) < 3;
    srcNow[3] = extRun ? ((extCnt % 20) < 10) : extForce;
    srcNow[4] = (cyc % 4) < 2;
    srcNow[5] = (cyc % 14) < 7;
  end

  assign chRecClk = {{21{srcNow[0]}}, srcNow[1], {7{srcNow[0]}}};
  assign chJaClk  = {29{srcNow[2]}};
  assign extClk   = srcNow[3];
  assign synthClk = srcNow[4];
  assign mlockClk = srcNow[5];

  refClkSel i_refClkSel (
    .mclk(mclk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgSrcSel(cfgSrcSel),
    .cfgT1E1(cfgT1E1), .cfgJaBypass(cfgJaBypass), .cfgSynthBypass(cfgSynthBypass),
    .cfgFreeRun(cfgFreeRun), .cfgHoldHigh(cfgHoldHigh), .cfgFreq(cfgFreq),
    .chRecClk(chRecClk), .chJaClk(chJaClk), .chLos(chLos), .extClk(extClk),
    .synthClk(synthClk), .mlockClk(mlockClk), .refClkOut(refClkOut), .refClkOe(refClkOe)
  );

  task automatic chk(input bit ok, input string rq, input logic act, input logic exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic setCfg(input logic en, input logic [4:0] sel, input logic sb,
                        input logic fr, input logic ja);
    @(negedge mclk);
    cfgEnable = en; cfgSrcSel = sel; cfgSynthBypass = sb;
    cfgFreeRun = fr; cfgJaBypass = ja;
  endtask

  // output must equal source id delayed by two cycles, every cycle of the window
  task automatic follow(input int id, input int n, input string rq);
    int bad = 0;
    logic a = 1'b0;
    logic e = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge mclk); #2;
      if (refClkOut !== prevSrc[id]) begin
        if (bad == 0) begin a = refClkOut; e = prevSrc[id]; end
        bad++;
      end
    end
    chk(bad == 0, rq, a, e);
  endtask

  task automatic steady(input logic v, input int n, input string rq);
    int bad = 0;
    logic a = v;
    for (int i = 0; i < n; i++) begin
      @(posedge mclk); #2;
      if (refClkOut !== v) begin bad++; a = refClkOut; end
    end
    chk(bad == 0, rq, a, v);
  endtask

  task automatic tReset();
    @(posedge mclk); #2;
    chk(refClkOut === 1'b0 && refClkOe === 1'b0, "R1 reset state", refClkOut | refClkOe, 1'b0);
  endtask

  task automatic tSourceSelect();
    setCfg(1, 5'd3, 1, 0, 1); idle(30);
    follow(0, 40, "R2 R4 channel 3 recovered clock");
    @(posedge mclk); #2;
    chk(refClkOe === 1'b1, "R1 enable drives oe", refClkOe, 1'b1);
    setCfg(1, 5'd7, 1, 0, 1); idle(30);
    follow(1, 40, "R2 channel 7 recovered clock");
    setCfg(1, 5'd7, 1, 0, 0); idle(30);
    follow(2, 40, "R3 attenuated tap");
    setCfg(1, 5'd28, 1, 0, 1); idle(30);
    follow(0, 40, "R2 last channel code 28");
    setCfg(1, 5'b11101, 1, 0, 1); idle(40);
    follow(3, 60, "R2 external code 11101");
    setCfg(1, 5'b11111, 1, 0, 1); idle(40);
    follow(3, 60, "R2 external code 11111");
  endtask

  task automatic tSynthAndFree();
    setCfg(1, 5'd3, 0, 0, 1); idle(30);
    follow(4, 40, "R5 synthesizer clock");
    @(negedge mclk) cfgFreq = 3'b110;
    setCfg(1, 5'd3, 0, 1, 1); idle(30);
    follow(5, 40, "R6 free-run master-locked");
    @(negedge mclk) cfgFreq = 3'b000; idle(30);
    steady(1'b1, 30, "R7 reserved code 000 high");
    @(negedge mclk) cfgFreq = 3'b011; idle(30);
    steady(1'b1, 30, "R7 reserved code 011 high");
    @(negedge mclk) cfgFreq = 3'b010; idle(30);
    follow(5, 30, "R7 non-reserved code 010 runs");
  endtask

  task automatic tChannelLos();
    setCfg(1, 5'd3, 1, 0, 1);
    @(negedge mclk) begin chLos = 29'h0000_0020; cfgHoldHigh = 1'b1; end
    idle(30);
    follow(0, 40, "R8 unselected channel LOS ignored");
    @(negedge mclk) chLos = 29'h0000_0008; idle(30);
    steady(1'b1, 30, "R8 LOS with hold-high");
    @(negedge mclk) cfgHoldHigh = 1'b0; idle(30);
    follow(5, 40, "R8 LOS falls back to master-locked");
    setCfg(1, 5'd3, 0, 1, 1); idle(30);
    follow(5, 30, "R6 free-run over channel LOS");
    @(negedge mclk) chLos = '0;
  endtask

  task automatic tExtLoss();
    setCfg(1, 5'b11101, 1, 0, 1);
    @(negedge mclk) cfgT1E1 = 1'b1; idle(60);
    @(negedge mclk) begin extRun = 1'b0; extForce = 1'b0; end
    idle(440);
    steady(1'b0, 5, "R9 E1 window not yet expired");
    idle(95);
    steady(1'b1, 20, "R10 E1 loss drives high");
    // a single edge must not restore the source
    @(negedge mclk) extForce = 1'b1; idle(10);
    @(negedge mclk) extForce = 1'b0; idle(60);
    steady(1'b1, 30, "R11 one edge keeps loss");
    @(negedge mclk) begin cfgT1E1 = 1'b0; extRun = 1'b1; end
    idle(80);
    follow(3, 60, "R11 two edges restore external");
    @(negedge mclk) extRun = 1'b0; idle(600);
    steady(1'b0, 5, "R9 T1 window longer than E1");
    idle(95);
    steady(1'b1, 20, "R9 R10 T1 loss drives high");
    setCfg(1, 5'b11101, 0, 0, 1); idle(30);
    steady(1'b1, 20, "R10 loss with synthesizer, free off");
    setCfg(1, 5'b11101, 0, 1, 1); idle(30);
    follow(5, 40, "R10 loss in free-run master-locked");
    @(negedge mclk) extRun = 1'b1; idle(80);
  endtask

  task automatic watchPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge mclk); #2;
      if (refClkOut) runLen++;
      else begin
        if (lastOut && runLen < 2) shortPulses++;
        runLen = 0;
      end
      lastOut = refClkOut;
    end
  endtask

  task automatic tGlitchFree();
    setCfg(1, 5'd3, 1, 0, 1); idle(30);
    runLen = 100; lastOut = refClkOut;
    for (int k = 0; k < 8; k++) begin
      setCfg(1, 5'd3, k[0], 0, 1);
      watchPulses(17);
    end
    setCfg(1, 5'd7, 1, 0, 1); watchPulses(13);
    setCfg(1, 5'd3, 1, 0, 0); watchPulses(13);
    chk(shortPulses == 0, "R12 no runt pulse on switch", shortPulses != 0, 1'b0);
  endtask

  task automatic tDisable();
    setCfg(0, 5'd3, 1, 0, 1);
    @(posedge mclk); #2;
    chk(refClkOe === 1'b0, "R1 oe drops one cycle after disable", refClkOe, 1'b0);
    idle(30);
    steady(1'b0, 20, "R1 disabled output low");
  endtask

  initial begin
    tReset();
    repeat (3) @(negedge mclk);
    rstN = 1'b1;
    tSourceSelect();
    tSynthAndFree();
    tChannelLos();
    tExtLoss();
    tGlitchFree();
    tDisable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule